// File: doc/BRIEF.md
# Tightly Coupled Accumulator Extension Unit

This block sits beside a host DSP core and behaves like one more execution unit of that core. The host sends an 8-bit extension instruction with a valid strobe one cycle ahead of the data. The block decodes that instruction early and registers the decoded control. In the following cycle the host presents the operands: three 16-bit memory read words, a 40-bit and a 41-bit accumulator value, a 4-bit arithmetic mode word and a 4-bit pipeline indicator word. The block registers those operands and executes in a single cycle against a small local register file. Results go back through registered 40-bit and 41-bit accumulator write ports, each with a write strobe.

The upper three instruction bits name one of up to eight attached extensions. The lower five bits name the operation. Debug download and upload operations move values between the host accumulator and the local register file. The upload operation also returns an identity word that reports the register count and an extension type code. A stall indicator freezes every stage. Any of the three cancel indicators kills the operation whose operands are being presented.

Top module: `dsp_ext_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `acc_a_out`, `acc_b_out`, `acc_a_we` and `acc_b_we` are all zero.
- R2: An instruction is accepted only when `ins_valid` is 1 and `ins_code[7:5]` equals parameter EXT_INDEX (default 5). Any other instruction produces no write strobe, leaves both result ports unchanged and leaves the register file unchanged.
- R3: An instruction presented in cycle t takes its operands, mode and pipeline word from cycle t+1, and its result and strobes appear in cycle t+3. One instruction may be issued every cycle.
- R4: Opcodes are in `ins_code[4:0]`. The local index is `mem_d[2:0]`, and it is valid only when `mem_d[15:3]` is zero. 0x01 computes acc_a + mem_b. 0x02 computes RF[idx] + acc_a. 0x03 computes RF[idx] + mem_b*mem_c. Each result goes to `acc_a_out` with `acc_a_we`=1, and to RF[idx] when the index is valid; an invalid index reads as zero.
- R5: Mode word bits (applied to 0x01–0x03): bit0 saturates the result to the signed 32-bit range; bit1 treats mem_b and mem_c as unsigned in 0x03; bit2 uses zero in place of RF[idx]; bit3 subtracts the second term instead of adding it. Without bit0 the result wraps to 40 bits.
- R6: Opcode 0x04 returns acc_a unchanged on `acc_a_out` and acc_b + sign-extended acc_a (41-bit wrap) on `acc_b_out`, with both strobes set and no register-file write.
- R7: Opcode 0x1E writes acc_a into RF[idx] (valid index only) with no strobes. Opcode 0x1F returns RF[idx] (zero when the index is invalid) on `acc_a_out`, and the identity word {EXT_TYPE in bits 15:8, register count in bits 7:0} on `acc_b_out`, with both strobes set.
- R8: While `pipe_in[0]` (stall) is 1, no stage advances, no register-file write occurs, both strobes are 0 in the following cycle and both result ports hold.
- R9: If any of `pipe_in[3:1]` is 1 in an instruction's operand cycle (and no stall), that instruction produces no strobe and no register-file write.
- R10: Opcodes other than those listed change neither result port nor the register file, and a result port changes only in a cycle where its strobe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_code | input | 8 | Extension select (7:5) and opcode (4:0) |
| ins_valid | input | 1 | Instruction strobe |
| mem_b | input | 16 | First memory read word |
| mem_c | input | 16 | Second memory read word |
| mem_d | input | 16 | Third memory read word, local index |
| acc_a_in | input | 40 | First accumulator operand |
| acc_b_in | input | 41 | Second accumulator operand |
| status_in | input | 4 | Arithmetic mode bits |
| pipe_in | input | 4 | Stall (bit 0) and cancel indicators (bits 3:1) |
| acc_a_out | output | 40 | First accumulator result |
| acc_b_out | output | 41 | Second accumulator result |
| acc_a_we | output | 1 | First result strobe |
| acc_b_we | output | 1 | Second result strobe |

## Verification
The hardest situation to reach is a stall or cancel that lands while three different instructions sit in the decode, operand and execute stages. The stall must then freeze all three without losing the pair split across cycles, and a cancel must kill only the middle one. The stimulus gets there with a long back-to-back stream. Stall and cancel are raised independently at random in that stream, and it mixes foreign extension indices, out-of-range local indices and every mode bit. Directed phases before it preload the register file and drive the saturation edges.

// File: rtl/dspx_pkg.sv
`timescale 1ns/1ps
package dspx_pkg;
   localparam int OPW = 5;

   localparam logic [OPW-1:0] OPC_ADD   = 5'h01;
   localparam logic [OPW-1:0] OPC_ACC   = 5'h02;
   localparam logic [OPW-1:0] OPC_MAC   = 5'h03;
   localparam logic [OPW-1:0] OPC_PAIR  = 5'h04;
   localparam logic [OPW-1:0] OPC_DLOAD = 5'h1E;
   localparam logic [OPW-1:0] OPC_ULOAD = 5'h1F;

   // one-hot decoded control, produced a cycle ahead of the operands
   typedef struct packed {
      logic add;
      logic acc;
      logic mac;
      logic pair;
      logic dload;
      logic uload;
   } dspx_dec_t;

   function automatic dspx_dec_t dspx_decode_op(input logic [OPW-1:0] op);
      dspx_dec_t d;
      d       = '0;
      d.add   = (op == OPC_ADD);
      d.acc   = (op == OPC_ACC);
      d.mac   = (op == OPC_MAC);
      d.pair  = (op == OPC_PAIR);
      d.dload = (op == OPC_DLOAD);
      d.uload = (op == OPC_ULOAD);
      return d;
   endfunction
endpackage

// File: rtl/dspx_decode.sv
`timescale 1ns/1ps
module dspx_decode
   import dspx_pkg::*;
#(
   parameter int INS_W     = 8,
   parameter int EXT_INDEX = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic [INS_W-1:0] ins_code,
   input  logic             ins_valid,
   output dspx_dec_t        dec_q
);
   localparam int SEL_W = INS_W - OPW;

   logic      sel_hit;
   dspx_dec_t dec_d;

   assign sel_hit = ins_valid && (ins_code[INS_W-1:OPW] == SEL_W'(EXT_INDEX));
   assign dec_d   = sel_hit ? dspx_decode_op(ins_code[OPW-1:0]) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)     dec_q <= '0;
      else if (!hold) dec_q <= dec_d;
   end
endmodule

// File: rtl/dspx_opnd.sv
`timescale 1ns/1ps
module dspx_opnd
   import dspx_pkg::*;
#(
   parameter int M_W = 16,
   parameter int A_W = 40,
   parameter int B_W = 41,
   parameter int S_W = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hold,
   input  logic           cancel,
   input  dspx_dec_t      dec_in,
   input  logic [M_W-1:0] mem_b,
   input  logic [M_W-1:0] mem_c,
   input  logic [M_W-1:0] mem_d,
   input  logic [A_W-1:0] acc_a,
   input  logic [B_W-1:0] acc_b,
   input  logic [S_W-1:0] status,
   output dspx_dec_t      dec_q,
   output logic [M_W-1:0] mem_b_q,
   output logic [M_W-1:0] mem_c_q,
   output logic [M_W-1:0] mem_d_q,
   output logic [A_W-1:0] acc_a_q,
   output logic [B_W-1:0] acc_b_q,
   output logic [S_W-1:0] status_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_q    <= '0;
         mem_b_q  <= '0;
         mem_c_q  <= '0;
         mem_d_q  <= '0;
         acc_a_q  <= '0;
         acc_b_q  <= '0;
         status_q <= '0;
      end else if (!hold) begin
         dec_q    <= cancel ? '0 : dec_in;
         mem_b_q  <= mem_b;
         mem_c_q  <= mem_c;
         mem_d_q  <= mem_d;
         acc_a_q  <= acc_a;
         acc_b_q  <= acc_b;
         status_q <= status;
      end
   end
endmodule

// File: rtl/dspx_regfile.sv
`timescale 1ns/1ps
module dspx_regfile #(
   parameter int DEPTH = 8,
   parameter int W     = 40
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] addr,
   input  logic [W-1:0]             wdata,
   output logic [W-1:0]             rdata
);
   localparam int IW = $clog2(DEPTH);

   logic [W-1:0] rows [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                          q <= '0;
         else if (we && (addr == IW'(g)))     q <= wdata;
      end
      assign rows[g] = q;
   end

   assign rdata = rows[addr];
endmodule

// File: rtl/dspx_exec.sv
`timescale 1ns/1ps
module dspx_exec
   import dspx_pkg::*;
#(
   parameter int       M_W      = 16,
   parameter int       A_W      = 40,
   parameter int       B_W      = 41,
   parameter int       S_W      = 4,
   parameter int       DEPTH    = 8,
   parameter int       SAT_W    = 32,
   parameter bit       HAS_SAT  = 1'b1,
   parameter bit [7:0] EXT_TYPE = 8'h3C
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     hold,
   input  dspx_dec_t                dec,
   input  logic [M_W-1:0]           mem_b,
   input  logic [M_W-1:0]           mem_c,
   input  logic [M_W-1:0]           mem_d,
   input  logic [A_W-1:0]           acc_a,
   input  logic [B_W-1:0]           acc_b,
   input  logic [S_W-1:0]           status,
   input  logic [A_W-1:0]           rf_rdata,
   output logic                     rf_we,
   output logic [$clog2(DEPTH)-1:0] rf_addr,
   output logic [A_W-1:0]           rf_wdata,
   output logic [A_W-1:0]           acc_a_out,
   output logic [B_W-1:0]           acc_b_out,
   output logic                     acc_a_we,
   output logic                     acc_b_we
);
   localparam int IW = $clog2(DEPTH);
   localparam int WW = A_W + 1;
   localparam int PW = 2 * M_W + 2;
   localparam logic signed [WW-1:0] SAT_HI = {{(WW-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
   localparam logic signed [WW-1:0] SAT_LO = {{(WW-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};
   localparam logic [B_W-1:0] ID_WORD = {{(B_W-16){1'b0}}, EXT_TYPE, 8'(DEPTH)};

   // mode bit positions
   localparam int MB_SAT = 0;
   localparam int MB_UNS = 1;
   localparam int MB_FRESH = 2;
   localparam int MB_SUB = 3;

   logic                  idx_ok;
   logic signed [WW-1:0]  a_s, b_s, base_s, prod_s, first_s, second_s, sum;
   logic signed [M_W:0]   ext_b, ext_c;
   logic signed [PW-1:0]  prod;
   logic [A_W-1:0]        clipped;
   logic [B_W-1:0]        pair_sum;
   logic                  arith;

   assign idx_ok  = (mem_d[M_W-1:IW] == '0);
   assign rf_addr = mem_d[IW-1:0];
   assign arith   = dec.add | dec.acc | dec.mac;

   assign a_s    = {acc_a[A_W-1], acc_a};
   assign b_s    = {{(WW-M_W){mem_b[M_W-1]}}, mem_b};
   assign base_s = (status[MB_FRESH] || !idx_ok) ? '0 : {rf_rdata[A_W-1], rf_rdata};
   assign ext_b  = {(status[MB_UNS] ? 1'b0 : mem_b[M_W-1]), mem_b};
   assign ext_c  = {(status[MB_UNS] ? 1'b0 : mem_c[M_W-1]), mem_c};
   assign prod   = ext_b * ext_c;
   assign prod_s = {{(WW-PW){prod[PW-1]}}, prod};

   always_comb begin
      if (dec.add) begin
         first_s  = a_s;
         second_s = b_s;
      end else if (dec.acc) begin
         first_s  = base_s;
         second_s = a_s;
      end else begin
         first_s  = base_s;
         second_s = prod_s;
      end
      sum = status[MB_SUB] ? (first_s - second_s) : (first_s + second_s);
   end

   if (HAS_SAT) begin : g_sat
      always_comb begin
         if (status[MB_SAT] && (sum > SAT_HI))      clipped = SAT_HI[A_W-1:0];
         else if (status[MB_SAT] && (sum < SAT_LO)) clipped = SAT_LO[A_W-1:0];
         else                                       clipped = sum[A_W-1:0];
      end
   end else begin : g_wrap
      assign clipped = sum[A_W-1:0];
   end

   assign pair_sum = acc_b + {{(B_W-A_W){acc_a[A_W-1]}}, acc_a};

   assign rf_we    = !hold && idx_ok && (arith | dec.dload);
   assign rf_wdata = dec.dload ? acc_a : clipped;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_a_out <= '0;
         acc_b_out <= '0;
         acc_a_we  <= 1'b0;
         acc_b_we  <= 1'b0;
      end else if (hold) begin
         acc_a_we  <= 1'b0;
         acc_b_we  <= 1'b0;
      end else begin
         acc_a_we  <= arith | dec.pair | dec.uload;
         acc_b_we  <= dec.pair | dec.uload;
         if (arith) acc_a_out <= clipped;
         if (dec.pair) begin
            acc_a_out <= acc_a;
            acc_b_out <= pair_sum;
         end
         if (dec.uload) begin
            acc_a_out <= idx_ok ? rf_rdata : '0;
            acc_b_out <= ID_WORD;
         end
      end
   end
endmodule

// File: rtl/dsp_ext_unit.sv
`timescale 1ns/1ps
module dsp_ext_unit
   import dspx_pkg::*;
#(
   parameter int       INS_W     = 8,
   parameter int       M_W       = 16,
   parameter int       A_W       = 40,
   parameter int       B_W       = 41,
   parameter int       S_W       = 4,
   parameter int       P_W       = 4,
   parameter int       RF_DEPTH  = 8,
   parameter int       EXT_INDEX = 5,
   parameter bit [7:0] EXT_TYPE  = 8'h3C,
   parameter int       SAT_W     = 32,
   parameter bit       HAS_SAT   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INS_W-1:0] ins_code,
   input  logic             ins_valid,
   input  logic [M_W-1:0]   mem_b,
   input  logic [M_W-1:0]   mem_c,
   input  logic [M_W-1:0]   mem_d,
   input  logic [A_W-1:0]   acc_a_in,
   input  logic [B_W-1:0]   acc_b_in,
   input  logic [S_W-1:0]   status_in,
   input  logic [P_W-1:0]   pipe_in,
   output logic [A_W-1:0]   acc_a_out,
   output logic [B_W-1:0]   acc_b_out,
   output logic             acc_a_we,
   output logic             acc_b_we
);
   localparam int IW = $clog2(RF_DEPTH);

   if (RF_DEPTH < 2 || RF_DEPTH > 32 || (1 << IW) != RF_DEPTH) begin : g_bad_depth
      $error("RF_DEPTH must be a power of two from 2 to 32");
   end
   if (INS_W != OPW + 3) begin : g_bad_ins
      $error("INS_W must leave three select bits above the opcode");
   end
   if (EXT_INDEX < 0 || EXT_INDEX > 7) begin : g_bad_index
      $error("EXT_INDEX must fit the three select bits");
   end
   if (B_W <= A_W || B_W < 16) begin : g_bad_bw
      $error("second accumulator must be wider than the first and at least 16 bits");
   end
   if (SAT_W >= A_W || 2 * M_W + 2 > A_W + 1) begin : g_bad_aw
      $error("first accumulator too narrow for product or saturation width");
   end
   if (S_W != 4 || P_W < 2 || M_W <= IW) begin : g_bad_misc
      $error("mode word must be 4 bits, pipeline word at least 2, memory word wider than index");
   end

   logic                 hold, cancel;
   dspx_dec_t            dec_s1, dec_s2;
   logic [M_W-1:0]       b_q, c_q, d_q;
   logic [A_W-1:0]       a_q;
   logic [B_W-1:0]       bb_q;
   logic [S_W-1:0]       st_q;
   logic                 rf_we;
   logic [IW-1:0]        rf_addr;
   logic [A_W-1:0]       rf_wdata, rf_rdata;

   assign hold   = pipe_in[0];
   assign cancel = |pipe_in[P_W-1:1];

   dspx_decode #(.INS_W(INS_W), .EXT_INDEX(EXT_INDEX)) u_dec (
      .clk(clk), .rst_n(rst_n), .hold(hold),
      .ins_code(ins_code), .ins_valid(ins_valid), .dec_q(dec_s1)
   );

   dspx_opnd #(.M_W(M_W), .A_W(A_W), .B_W(B_W), .S_W(S_W)) u_opnd (
      .clk(clk), .rst_n(rst_n), .hold(hold), .cancel(cancel), .dec_in(dec_s1),
      .mem_b(mem_b), .mem_c(mem_c), .mem_d(mem_d), .acc_a(acc_a_in), .acc_b(acc_b_in),
      .status(status_in), .dec_q(dec_s2), .mem_b_q(b_q), .mem_c_q(c_q), .mem_d_q(d_q),
      .acc_a_q(a_q), .acc_b_q(bb_q), .status_q(st_q)
   );

   dspx_regfile #(.DEPTH(RF_DEPTH), .W(A_W)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(rf_we), .addr(rf_addr),
      .wdata(rf_wdata), .rdata(rf_rdata)
   );

   dspx_exec #(
      .M_W(M_W), .A_W(A_W), .B_W(B_W), .S_W(S_W), .DEPTH(RF_DEPTH),
      .SAT_W(SAT_W), .HAS_SAT(HAS_SAT), .EXT_TYPE(EXT_TYPE)
   ) u_exec (
      .clk(clk), .rst_n(rst_n), .hold(hold), .dec(dec_s2),
      .mem_b(b_q), .mem_c(c_q), .mem_d(d_q), .acc_a(a_q), .acc_b(bb_q), .status(st_q),
      .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
      .acc_a_out(acc_a_out), .acc_b_out(acc_b_out), .acc_a_we(acc_a_we), .acc_b_we(acc_b_we)
   );
endmodule

// File: rtl/dspx_checker.sv
`timescale 1ns/1ps
module dspx_checker #(
   parameter int INS_W     = 8,
   parameter int A_W       = 40,
   parameter int B_W       = 41,
   parameter int P_W       = 4,
   parameter int EXT_INDEX = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [INS_W-1:0] ins_code,
   input logic             ins_valid,
   input logic [P_W-1:0]   pipe_in,
   input logic [A_W-1:0]   acc_a_out,
   input logic [B_W-1:0]   acc_b_out,
   input logic             acc_a_we,
   input logic             acc_b_we
);
   localparam logic [INS_W-1:0] ADD_CODE = {3'(EXT_INDEX), 5'h01};

   logic stall, kill, add_issue, foreign_issue;
   assign stall         = pipe_in[0];
   assign kill          = |pipe_in[P_W-1:1];
   assign add_issue     = ins_valid && (ins_code == ADD_CODE) && !stall;
   assign foreign_issue = ins_valid && (ins_code[INS_W-1:INS_W-3] != 3'(EXT_INDEX)) && !stall;

   assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      add_issue ##1 (!stall && !kill) ##1 !stall |=> acc_a_we);

   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (!acc_a_we && !acc_b_we && $stable(acc_a_out) && $stable(acc_b_out)));

   assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      add_issue ##1 (!stall && kill) ##1 !stall |=> !acc_a_we);

   assert_foreign_R2: assert property (@(posedge clk) disable iff (!rst_n)
      foreign_issue ##1 !stall ##1 !stall |=> (!acc_a_we && !acc_b_we));

   assert_a_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_a_we |-> $stable(acc_a_out));

   assert_b_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_b_we |-> $stable(acc_b_out));

   assert_pair_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_b_we |-> acc_a_we);
endmodule

bind dsp_ext_unit dspx_checker #(
   .INS_W(INS_W), .A_W(A_W), .B_W(B_W), .P_W(P_W), .EXT_INDEX(EXT_INDEX)
) u_dspx_chk (
   .clk(clk), .rst_n(rst_n), .ins_code(ins_code), .ins_valid(ins_valid),
   .pipe_in(pipe_in), .acc_a_out(acc_a_out), .acc_b_out(acc_b_out),
   .acc_a_we(acc_a_we), .acc_b_we(acc_b_we)
);

// File: tb/tb_dsp_ext_unit.sv
`timescale 1ns/1ps
module tb_dsp_ext_unit;
   localparam int IDX = 5;
   localparam logic [40:0] ID_EXP = {25'd0, 8'h3C, 8'd8};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  t_code = '0;
   logic        t_valid = 1'b0;
   logic [15:0] t_mb = '0, t_mc = '0, t_md = '0;
   logic [39:0] t_aa = '0;
   logic [40:0] t_ab = '0;
   logic [3:0]  t_st = '0, t_pipe = '0;

   logic [39:0] acc_a_out;
   logic [40:0] acc_b_out;
   logic        acc_a_we, acc_b_we;

   always #2.5 clk = ~clk;

   dsp_ext_unit dut (
      .clk(clk), .rst_n(rst_n), .ins_code(t_code), .ins_valid(t_valid),
      .mem_b(t_mb), .mem_c(t_mc), .mem_d(t_md), .acc_a_in(t_aa), .acc_b_in(t_ab),
      .status_in(t_st), .pipe_in(t_pipe), .acc_a_out(acc_a_out), .acc_b_out(acc_b_out),
      .acc_a_we(acc_a_we), .acc_b_we(acc_b_we)
   );

   int    n_cmp = 0, n_bad = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // behavioural reference model
   logic [39:0] m_rf [8];
   bit          m_s1_v, m_ex_v;
   logic [4:0]  m_s1_op, m_ex_op;
   logic [15:0] m_b, m_c, m_d;
   logic [39:0] m_aa;
   logic [40:0] m_ab;
   logic [3:0]  m_st;
   logic [39:0] e_a;
   logic [40:0] e_b;
   bit          e_awe, e_bwe;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_rf[i]) m_rf[i] = '0;
         m_s1_v = 0; m_ex_v = 0; m_s1_op = '0; m_ex_op = '0;
         e_a = '0; e_b = '0; e_awe = 0; e_bwe = 0;
      end else if (t_pipe[0]) begin
         e_awe = 0; e_bwe = 0;
      end else begin
         e_awe = 0; e_bwe = 0;
         if (m_ex_v) begin
            int     ix;
            bit     ok;
            longint base, fa, ad, s;
            ix   = int'(m_d[2:0]);
            ok   = (m_d[15:3] == 0);
            base = (m_st[2] || !ok) ? 64'sd0 : longint'($signed(m_rf[ix]));
            if (m_ex_op inside {5'h01, 5'h02, 5'h03}) begin
               if (m_ex_op == 5'h01) begin
                  fa = longint'($signed(m_aa)); ad = longint'($signed(m_b));
               end else if (m_ex_op == 5'h02) begin
                  fa = base; ad = longint'($signed(m_aa));
               end else begin
                  fa = base;
                  if (m_st[1]) ad = longint'(m_b) * longint'(m_c);
                  else         ad = longint'($signed(m_b)) * longint'($signed(m_c));
               end
               s = m_st[3] ? fa - ad : fa + ad;
               if (m_st[0] && s > 64'sd2147483647) s = 64'sd2147483647;
               if (m_st[0] && s < -64'sd2147483648) s = -64'sd2147483648;
               e_a = s[39:0]; e_awe = 1;
               if (ok) m_rf[ix] = s[39:0];
            end else if (m_ex_op == 5'h04) begin
               e_a = m_aa; e_b = m_ab + {m_aa[39], m_aa}; e_awe = 1; e_bwe = 1;
            end else if (m_ex_op == 5'h1E) begin
               if (ok) m_rf[ix] = m_aa;
            end else if (m_ex_op == 5'h1F) begin
               e_a = ok ? m_rf[ix] : '0; e_b = ID_EXP; e_awe = 1; e_bwe = 1;
            end
         end
         m_ex_v  = m_s1_v && !(|t_pipe[3:1]);
         m_ex_op = m_s1_op;
         m_b = t_mb; m_c = t_mc; m_d = t_md; m_aa = t_aa; m_ab = t_ab; m_st = t_st;
         m_s1_v  = t_valid && (t_code[7:5] == 3'(IDX));
         m_s1_op = t_code[4:0];
      end
   end

   task automatic compare();
      n_cmp++;
      if (acc_a_out !== e_a || acc_b_out !== e_b || acc_a_we !== e_awe || acc_b_we !== e_bwe) begin
         n_bad++;
         $display("FAIL %s: a=%h b=%h awe=%b bwe=%b expected a=%h b=%h awe=%b bwe=%b",
                  cur_req, acc_a_out, acc_b_out, acc_a_we, acc_b_we, e_a, e_b, e_awe, e_bwe);
      end
   endtask

   task automatic cyc(input logic [7:0] code, input bit v, input logic [15:0] b, c, d,
                      input logic [39:0] aa, input logic [40:0] ab,
                      input logic [3:0] st, input logic [3:0] pp, input string req);
      @(negedge clk);
      compare();
      cur_req = req;
      t_code = code; t_valid = v; t_mb = b; t_mc = c; t_md = d;
      t_aa = aa; t_ab = ab; t_st = st; t_pipe = pp;
   endtask

   // issue one instruction, then its operands in the next cycle
   task automatic run(input logic [4:0] op, input logic [15:0] b, c, d,
                      input logic [39:0] aa, input logic [40:0] ab,
                      input logic [3:0] st, input string req);
      cyc({3'(IDX), op}, 1, 0, 0, 0, 0, 0, 0, 0, req);
      cyc(8'h00, 0, b, c, d, aa, ab, st, 0, req);
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++) cyc(8'h00, 0, 0, 0, 0, 0, 0, 0, 0, req);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values at the ports
      n_cmp++;
      if (acc_a_out !== '0 || acc_b_out !== '0 || acc_a_we !== 0 || acc_b_we !== 0) begin
         n_bad++;
         $display("FAIL R1: a=%h b=%h awe=%b bwe=%b expected all zero", acc_a_out, acc_b_out, acc_a_we, acc_b_we);
      end
      rst_n = 1'b1;
      idle(2, "R1");

      // R7: pipelined download of all entries, then upload with identity word
      for (int i = 0; i <= 8; i++)
         cyc(i < 8 ? {3'(IDX), 5'h1E} : 8'h00, i < 8, 0, 0, 16'(i - 1),
             40'h11_0000_0000 + 40'(i * 40'h0101_0101) - 40'h0101_0101, 0, 0, 0, "R7");
      for (int i = 0; i <= 8; i++)
         cyc(i < 8 ? {3'(IDX), 5'h1F} : 8'h00, i < 8, 0, 0, 16'(i - 1), 0, 0, 0, 0, "R7");
      run(5'h1F, 0, 0, 16'h0008, 0, 0, 0, "R7_bad_index");
      idle(3, "R7");

      // R4: basic arithmetic and register-file reuse, R3: latency
      run(5'h01, 16'hFFF0, 0, 16'd2, 40'd100, 0, 0, "R4_add");
      run(5'h02, 0, 0, 16'd2, 40'd7, 0, 0, "R4_acc");
      run(5'h03, 16'h0012, 16'hFFFD, 16'd2, 0, 0, 0, "R4_mac");
      run(5'h03, 16'h0012, 16'hFFFD, 16'h0100, 0, 0, 0, "R4_bad_index");
      run(5'h1F, 0, 0, 16'd2, 0, 0, 0, "R4_readback");
      idle(3, "R3");

      // R5: mode bits
      run(5'h01, 16'h0100, 0, 16'd3, 40'h00_7FFF_FFF0, 0, 4'b0001, "R5_sat_hi");
      run(5'h01, 16'h0100, 0, 16'd3, 40'h00_7FFF_FFF0, 0, 4'b0000, "R5_wrap");
      run(5'h01, 16'h0100, 0, 16'd3, 40'hFF_8000_0010, 0, 4'b1001, "R5_sat_lo");
      run(5'h03, 16'hFFFF, 16'hFFFF, 16'd4, 0, 0, 4'b0110, "R5_unsigned_fresh");
      run(5'h03, 16'hFFFF, 16'hFFFF, 16'd4, 0, 0, 4'b0000, "R5_signed");
      run(5'h02, 0, 0, 16'd4, 40'd5, 0, 4'b1000, "R5_sub");
      idle(3, "R5");

      // R6: paired accumulator op
      run(5'h04, 0, 0, 0, 40'hFF_FFFF_FFFE, 41'h000_0000_0005, 0, "R6_pair");
      run(5'h04, 0, 0, 0, 40'h12_3456_789A, 41'h1FF_FFFF_FFFF, 0, "R6_wrap");
      idle(3, "R6");

      // R2: foreign extension index ignored, R10: unknown opcode ignored
      cyc({3'd2, 5'h01}, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
      cyc({3'd2, 5'h1E}, 1, 16'h7777, 0, 16'd1, 40'hAA, 0, 0, 0, "R2");
      cyc(8'h00, 0, 0, 0, 16'd1, 40'hBB, 0, 0, 0, "R2");
      run(5'h07, 16'h55, 16'h66, 16'd1, 40'hCC, 41'hDD, 0, "R10");
      run(5'h1F, 0, 0, 16'd1, 0, 0, 0, "R10_readback");
      idle(3, "R10");

      // R8: stall in the middle of back-to-back traffic
      cyc({3'(IDX), 5'h01}, 1, 0, 0, 0, 0, 0, 0, 0, "R8");
      cyc({3'(IDX), 5'h02}, 1, 16'd3, 0, 16'd5, 40'd10, 0, 0, 0, "R8");
      cyc({3'(IDX), 5'h02}, 1, 0, 0, 16'd5, 40'd20, 0, 0, 4'b0001, "R8");
      cyc({3'(IDX), 5'h02}, 1, 0, 0, 16'd5, 40'd20, 0, 0, 4'b0001, "R8");
      cyc(8'h00, 0, 0, 0, 16'd5, 40'd20, 0, 0, 0, "R8");
      idle(4, "R8");

      // R9: cancel in operand cycle
      cyc({3'(IDX), 5'h01}, 1, 0, 0, 0, 0, 0, 0, 0, "R9");
      cyc({3'(IDX), 5'h1E}, 1, 16'd9, 0, 16'd6, 40'd9, 0, 0, 4'b0010, "R9");
      cyc({3'(IDX), 5'h1F}, 1, 0, 0, 16'd6, 40'h77, 0, 0, 4'b1000, "R9");
      cyc(8'h00, 0, 0, 0, 16'd6, 0, 0, 0, 0, "R9");
      run(5'h1F, 0, 0, 16'd6, 0, 0, 0, "R9_readback");
      idle(3, "R9");

      // R3: long back-to-back mixed stream with random stall and cancel
      for (int i = 0; i < 1500; i++) begin
         logic [4:0] op;
         logic [2:0] sel;
         logic [15:0] d;
         logic [3:0] pp;
         case ($urandom % 8)
            0: op = 5'h01; 1: op = 5'h02; 2: op = 5'h03; 3: op = 5'h04;
            4: op = 5'h1E; 5: op = 5'h1F; 6: op = 5'h09; default: op = 5'h03;
         endcase
         sel = ($urandom % 5 == 0) ? 3'($urandom) : 3'(IDX);
         d   = ($urandom % 6 == 0) ? 16'($urandom) : 16'($urandom % 8);
         pp  = 4'b0000;
         if ($urandom % 8 == 0) pp[0] = 1'b1;
         if ($urandom % 9 == 0) pp[1 + ($urandom % 3)] = 1'b1;
         cyc({sel, op}, ($urandom % 6) != 0, 16'($urandom), 16'($urandom), d,
             {8'($urandom), 32'($urandom)}, {9'($urandom), 32'($urandom)},
             4'($urandom), pp, "R3_stream");
      end
      idle(5, "R3");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule